// File: doc/BRIEF.md
# SPI Command Sequencer

This block drives an SPI port from a stream of 16-bit instructions. It pulls one instruction at a time from a command queue and carries it out completely before it takes the next one. Every instruction splits into three fields: an opcode in bits 15:12, a 4-bit first argument in bits 11:8 and an 8-bit second argument in bits 7:0. Five kinds of instruction are defined: a byte transfer, a chip-select update with an optional settle delay, a write to one of two internal settings (the clock divider or the mode byte), a timed pause, and a sync marker. The sync marker reports an 8-bit tag once all earlier work has finished.

For a transfer, the block moves bytes between a transmit queue, a separate bit-level shifter and a receive queue. It waits whenever the transmit queue is empty or the receive queue is full. Pauses and chip-select delays are counted in units of one SPI half-period, which is (divider + 1) clock cycles. Software builds a program for each message and ends it with a sync marker. A rise on the sync output then tells software that the whole message, including every received byte, has arrived.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset, cs_n is 8'hFF, clk_div and spi_cfg are 0, sync_pulse is 0 and cmd_ready is 1.
- R2: Opcode 2 writes argument 2 into clk_div when argument 1 is 0 and into spi_cfg when argument 1 is 1. Any other argument-1 value changes neither setting. A written value is visible in the cycle after the instruction is accepted.
- R3: Opcode 1 drives cs_n to argument 2 in the cycle after acceptance (a 0 bit selects a device). cmd_ready then stays low for argument1 × (clk_div + 1) cycles; when argument 1 is 0 there is no delay.
- R4: Opcode 0 performs argument 2 + 1 byte exchanges, one sh_start per byte. It waits for sh_done before it starts the next byte.
- R5: When bit 0 of argument 1 is set in a transfer, each byte sent is popped from the transmit queue in order. When the bit is clear, the byte 8'h00 is sent and the transmit queue is not popped.
- R6: When bit 1 of argument 1 is set in a transfer, each sh_rdata byte is offered on rx_data in order. When the bit is clear, rx_valid never rises.
- R7: A write transfer starts no byte while tx_valid is low. An offered receive byte keeps rx_valid high and rx_data unchanged until rx_ready is high.
- R8: Opcode 3 with argument 1 equal to 1 keeps cmd_ready low for (argument2 + 1) × (clk_div + 1) cycles.
- R9: Opcode 3 with argument 1 equal to 0 sets sync_id to argument 2 and raises sync_pulse for one cycle. This happens only after every earlier received byte has been accepted by the receive queue.
- R10: Opcodes 4 to 15, and opcode 3 with argument 1 above 1, are consumed in one cycle and change no output.
- R11: cmd_ready is low whenever an instruction is still executing, so no new instruction is accepted while a transfer or delay is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command queue holds an instruction |
| cmd_data | input | 16 | Instruction word at the head of the command queue |
| cmd_ready | output | 1 | Instruction is taken (pop) when high together with cmd_valid |
| tx_valid | input | 1 | Transmit queue holds a byte |
| tx_data | input | 8 | Byte at the head of the transmit queue |
| tx_ready | output | 1 | Transmit byte is popped when high together with tx_valid |
| sh_start | output | 1 | Pulse that starts one byte exchange in the shifter |
| sh_wdata | output | 8 | Byte handed to the shifter with sh_start |
| sh_done | input | 1 | Shifter finished the current byte |
| sh_rdata | input | 8 | Byte received by the shifter, valid with sh_done |
| rx_valid | output | 1 | Received byte offered to the receive queue |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Receive queue has room |
| cs_n | output | 8 | Chip-select lines, active low |
| clk_div | output | 8 | Clock divider setting for the shifter |
| spi_cfg | output | 8 | Mode setting (phase, polarity, three-wire) for the shifter |
| sync_pulse | output | 1 | One-cycle sync event |
| sync_id | output | 8 | Tag of the last sync reached |

## Verification
A wrong state in the control machine shows up at once at cmd_ready. The port rises too early during a pause or transfer, or stays low after the work is done, so the bench counts the exact number of low cycles for each delay. If the byte engine counts wrongly, the number of sh_start pulses comes out off by one. A wrong hold of the receive byte shows as rx_data changing while rx_ready is low. If a sync overtakes its transfer, sync_pulse rises while a received byte is still being offered. The bench stalls the receive queue on purpose to expose that case.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int CMD_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int CS_W    = 8;
    localparam int ARG1_W  = 4;
    localparam int UNIT_W  = BYTE_W + 1;

    localparam logic [3:0] OPC_XFER = 4'd0;
    localparam logic [3:0] OPC_CSEL = 4'd1;
    localparam logic [3:0] OPC_WREG = 4'd2;
    localparam logic [3:0] OPC_MISC = 4'd3;

    typedef struct packed {
        logic [3:0]        op;
        logic [ARG1_W-1:0] a1;
        logic [BYTE_W-1:0] a2;
    } instr_t;

    typedef enum logic [2:0] {
        K_NOP,
        K_XFER,
        K_CSEL,
        K_WDIV,
        K_WCFG,
        K_SLEEP,
        K_SYNC
    } kind_t;

    typedef enum logic [1:0] {
        S_FETCH,
        S_WAIT,
        S_XFER
    } seq_state_t;

    typedef enum logic [1:0] {
        X_IDLE,
        X_LOAD,
        X_SHIFT,
        X_PUSH
    } xfer_state_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] last;
    } xfer_req_t;

    function automatic kind_t classify(instr_t i);
        kind_t k;
        k = K_NOP;
        case (i.op)
            OPC_XFER: k = K_XFER;
            OPC_CSEL: k = K_CSEL;
            OPC_WREG: begin
                if (i.a1 == 4'd0)      k = K_WDIV;
                else if (i.a1 == 4'd1) k = K_WCFG;
            end
            OPC_MISC: begin
                if (i.a1 == 4'd0)      k = K_SYNC;
                else if (i.a1 == 4'd1) k = K_SLEEP;
            end
            default: k = K_NOP;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
    parameter int UNIT_W = 9,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [UNIT_W-1:0] units,
    input  logic [DIV_W-1:0]  div,
    output logic              expire
);
    logic [UNIT_W-1:0] unit_cnt;
    logic [DIV_W-1:0]  tick_cnt;
    logic [DIV_W-1:0]  div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_cnt <= '0;
            tick_cnt <= '0;
            div_q    <= '0;
        end else if (load) begin
            unit_cnt <= units;
            tick_cnt <= div;
            div_q    <= div;
        end else if (unit_cnt != '0) begin
            if (tick_cnt == '0) begin
                unit_cnt <= unit_cnt - 1'b1;
                tick_cnt <= div_q;
            end else begin
                tick_cnt <= tick_cnt - 1'b1;
            end
        end
    end

    assign expire = (unit_cnt == UNIT_W'(1)) && (tick_cnt == '0);

endmodule

// File: rtl/spi_seq_regs.sv
module spi_seq_regs #(
    parameter int CS_W   = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              div_we,
    input  logic              cfg_we,
    input  logic              cs_we,
    input  logic              sync_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CS_W-1:0]   cs_n,
    output logic [BYTE_W-1:0] clk_div,
    output logic [BYTE_W-1:0] spi_cfg,
    output logic [BYTE_W-1:0] sync_id,
    output logic              sync_pulse
);
    localparam int CS_COPY = (CS_W < BYTE_W) ? CS_W : BYTE_W;

    logic [CS_W-1:0] cs_next;

    generate
        if (CS_W > BYTE_W) begin : g_wide_cs
            assign cs_next = {{(CS_W-BYTE_W){1'b1}}, wdata};
        end else begin : g_narrow_cs
            assign cs_next = wdata[CS_COPY-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n       <= '1;
            clk_div    <= '0;
            spi_cfg    <= '0;
            sync_id    <= '0;
            sync_pulse <= 1'b0;
        end else begin
            sync_pulse <= sync_we;
            if (cs_we)   cs_n    <= cs_next;
            if (div_we)  clk_div <= wdata;
            if (cfg_we)  spi_cfg <= wdata;
            if (sync_we) sync_id <= wdata;
        end
    end

endmodule

// File: rtl/spi_seq_xfer.sv
module spi_seq_xfer
    import spi_seq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_req_t         req,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              sh_start,
    output logic [BYTE_W-1:0] sh_wdata,
    input  logic              sh_done,
    input  logic [BYTE_W-1:0] sh_rdata,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    input  logic              rx_ready,
    output logic              done
);
    xfer_state_t       st;
    logic              wr_q;
    logic              rd_q;
    logic [BYTE_W-1:0] cnt;
    logic [BYTE_W-1:0] rx_q;
    logic              last_byte;

    assign last_byte = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= X_IDLE;
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            cnt  <= '0;
            rx_q <= '0;
        end else begin
            case (st)
                X_IDLE: begin
                    if (start) begin
                        wr_q <= req.wr;
                        rd_q <= req.rd;
                        cnt  <= req.last;
                        st   <= X_LOAD;
                    end
                end
                X_LOAD: begin
                    if (sh_start) st <= X_SHIFT;
                end
                X_SHIFT: begin
                    if (sh_done) begin
                        rx_q <= sh_rdata;
                        if (rd_q) begin
                            st <= X_PUSH;
                        end else if (last_byte) begin
                            st <= X_IDLE;
                        end else begin
                            cnt <= cnt - 1'b1;
                            st  <= X_LOAD;
                        end
                    end
                end
                X_PUSH: begin
                    if (rx_ready) begin
                        if (last_byte) begin
                            st <= X_IDLE;
                        end else begin
                            cnt <= cnt - 1'b1;
                            st  <= X_LOAD;
                        end
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_ready = (st == X_LOAD) && wr_q;
        sh_start = (st == X_LOAD) && (!wr_q || tx_valid);
        sh_wdata = wr_q ? tx_data : '0;
        rx_valid = (st == X_PUSH);
        rx_data  = rx_q;
        done     = ((st == X_SHIFT) && sh_done && !rd_q && last_byte) ||
                   ((st == X_PUSH) && rx_ready && last_byte);
    end

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [CMD_W-1:0]    cmd_data,
    output logic                cmd_ready,
    input  logic                tx_valid,
    input  logic [BYTE_W-1:0]   tx_data,
    output logic                tx_ready,
    output logic                sh_start,
    output logic [BYTE_W-1:0]   sh_wdata,
    input  logic                sh_done,
    input  logic [BYTE_W-1:0]   sh_rdata,
    output logic                rx_valid,
    output logic [BYTE_W-1:0]   rx_data,
    input  logic                rx_ready,
    output logic [CS_W-1:0]     cs_n,
    output logic [BYTE_W-1:0]   clk_div,
    output logic [BYTE_W-1:0]   spi_cfg,
    output logic                sync_pulse,
    output logic [BYTE_W-1:0]   sync_id
);
    seq_state_t        state;
    instr_t            ins;
    kind_t             kind;
    logic              accept;
    logic              timer_load;
    logic              timer_expire;
    logic [UNIT_W-1:0] timer_units;
    logic              xfer_start;
    logic              xfer_done;
    xfer_req_t         xreq;

    assign ins    = instr_t'(cmd_data);
    assign kind   = classify(ins);
    assign cmd_ready = (state == S_FETCH);
    assign accept = cmd_valid && cmd_ready;

    always_comb begin
        timer_load  = 1'b0;
        timer_units = '0;
        if (accept && kind == K_SLEEP) begin
            timer_load  = 1'b1;
            timer_units = UNIT_W'(ins.a2) + 1'b1;
        end else if (accept && kind == K_CSEL && ins.a1 != '0) begin
            timer_load  = 1'b1;
            timer_units = UNIT_W'(ins.a1);
        end
    end

    assign xfer_start = accept && (kind == K_XFER);
    assign xreq.wr    = ins.a1[0];
    assign xreq.rd    = ins.a1[1];
    assign xreq.last  = ins.a2;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_FETCH;
        end else begin
            case (state)
                S_FETCH: begin
                    if (xfer_start)      state <= S_XFER;
                    else if (timer_load) state <= S_WAIT;
                end
                S_WAIT: if (timer_expire) state <= S_FETCH;
                S_XFER: if (xfer_done)    state <= S_FETCH;
                default: state <= S_FETCH;
            endcase
        end
    end

    spi_seq_regs #(
        .CS_W   (CS_W),
        .BYTE_W (BYTE_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .div_we     (accept && kind == K_WDIV),
        .cfg_we     (accept && kind == K_WCFG),
        .cs_we      (accept && kind == K_CSEL),
        .sync_we    (accept && kind == K_SYNC),
        .wdata      (ins.a2),
        .cs_n       (cs_n),
        .clk_div    (clk_div),
        .spi_cfg    (spi_cfg),
        .sync_id    (sync_id),
        .sync_pulse (sync_pulse)
    );

    spi_seq_timer #(
        .UNIT_W (UNIT_W),
        .DIV_W  (BYTE_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (timer_load),
        .units  (timer_units),
        .div    (clk_div),
        .expire (timer_expire)
    );

    spi_seq_xfer #(
        .BYTE_W (BYTE_W)
    ) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .start    (xfer_start),
        .req      (xreq),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .sh_start (sh_start),
        .sh_wdata (sh_wdata),
        .sh_done  (sh_done),
        .sh_rdata (sh_rdata),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .done     (xfer_done)
    );

endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [15:0] cmd_data,
    input logic        cmd_ready,
    input logic        tx_valid,
    input logic [7:0]  tx_data,
    input logic        tx_ready,
    input logic        sh_start,
    input logic [7:0]  sh_wdata,
    input logic        sh_done,
    input logic [7:0]  sh_rdata,
    input logic        rx_valid,
    input logic [7:0]  rx_data,
    input logic        rx_ready,
    input logic [7:0]  cs_n,
    input logic [7:0]  clk_div,
    input logic [7:0]  spi_cfg,
    input logic        sync_pulse,
    input logic [7:0]  sync_id
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) begin
            a_r1_reset_state: assert (cs_n == 8'hFF && clk_div == 8'h00 &&
                                      spi_cfg == 8'h00 && cmd_ready && !sync_pulse);
        end
    end

    a_r2_settings_hold: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_ready) |=> ($stable(clk_div) && $stable(spi_cfg)));

    a_r3_cs_hold: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_ready) |=> $stable(cs_n));

    a_r7_no_start_when_tx_empty: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !tx_valid) |-> !sh_start);

    a_r7_rx_hold: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    a_r9_sync_tag: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> ($past(cmd_valid && cmd_ready) && sync_id == $past(cmd_data[7:0])));

    a_r11_idle_when_fetching: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (!sh_start && !rx_valid && !tx_ready));

endmodule

bind spi_cmd_seq spi_cmd_seq_chk u_chk (.*);

// File: tb/spi_cmd_seq_bench.sv
module spi_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        cmd_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready;
    logic        sh_start;
    logic [7:0]  sh_wdata;
    logic        sh_done;
    logic [7:0]  sh_rdata;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_ready = 1'b1;
    logic [7:0]  cs_n;
    logic [7:0]  clk_div;
    logic [7:0]  spi_cfg;
    logic        sync_pulse;
    logic [7:0]  sync_id;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    spi_cmd_seq u_spi_cmd_seq (.*);

    // transmit queue model
    logic [7:0] tx_mem [0:31];
    int tx_wr = 0;
    int tx_rd = 0;
    assign tx_valid = (tx_rd < tx_wr);
    assign tx_data  = tx_mem[tx_rd[4:0]];
    always @(posedge clk) if (tx_valid && tx_ready) tx_rd <= tx_rd + 1;

    // shifter model: done three cycles after start, returns byte ^ 8'hA5
    logic [7:0] sent_log [0:31];
    int sent_n = 0;
    int dly = 0;
    logic [7:0] rd_q = '0;
    logic done_q = 1'b0;
    assign sh_done  = done_q;
    assign sh_rdata = rd_q;
    always @(posedge clk) begin
        done_q <= 1'b0;
        if (sh_start) begin
            sent_log[sent_n[4:0]] <= sh_wdata;
            sent_n <= sent_n + 1;
            rd_q   <= sh_wdata ^ 8'hA5;
            dly    <= 3;
        end else if (dly != 0) begin
            dly <= dly - 1;
            if (dly == 1) done_q <= 1'b1;
        end
    end

    // receive queue model
    logic [7:0] rx_log [0:31];
    int rx_n = 0;
    always @(posedge clk) if (rx_valid && rx_ready) begin
        rx_log[rx_n[4:0]] <= rx_data;
        rx_n <= rx_n + 1;
    end

    // sync monitor
    int sync_n = 0;
    logic [7:0] sync_last = '0;
    always @(posedge clk) if (!rst && sync_pulse) begin
        sync_n    <= sync_n + 1;
        sync_last <= sync_id;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = c;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (!cmd_ready) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_mem[tx_wr[4:0]] = b;
        tx_wr++;
    endtask

    // {instruction, expected cs_n, expected clk_div, expected spi_cfg}
    localparam logic [39:0] VEC [9] = '{
        {16'h2005, 8'hFF, 8'h05, 8'h00},   // R2 divider write
        {16'h2103, 8'hFF, 8'h05, 8'h03},   // R2 config write
        {16'h10FE, 8'hFE, 8'h05, 8'h03},   // R3 select device 0
        {16'h107F, 8'h7F, 8'h05, 8'h03},   // R3 select device 7
        {16'h2700, 8'h7F, 8'h05, 8'h03},   // R2 unknown setting ignored
        {16'h5AFF, 8'h7F, 8'h05, 8'h03},   // R10 undefined opcode
        {16'h3255, 8'h7F, 8'h05, 8'h03},   // R10 undefined misc variant
        {16'h10FF, 8'hFF, 8'h05, 8'h03},   // R3 deselect all
        {16'h2000, 8'hFF, 8'h00, 8'h03}    // R2 divider back to zero
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int s0;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(cs_n == 8'hFF, "R1 cs_n", cs_n, 8'hFF);
        chk(clk_div == 0 && spi_cfg == 0, "R1 settings", {clk_div, spi_cfg}, 0);
        chk(cmd_ready && !sync_pulse, "R1 ready", {cmd_ready, sync_pulse}, 2);

        // table walk: settings, chip selects, ignored instructions
        for (int i = 0; i < 9; i++) begin
            s0 = sync_n;
            send(VEC[i][39:24]);
            chk(cmd_ready, "R10 one-cycle consume", cmd_ready, 1);
            chk(cs_n == VEC[i][23:16], "R3 cs_n vector", cs_n, VEC[i][23:16]);
            chk(clk_div == VEC[i][15:8], "R2 clk_div vector", clk_div, VEC[i][15:8]);
            chk(spi_cfg == VEC[i][7:0], "R2 spi_cfg vector", spi_cfg, VEC[i][7:0]);
            chk(sync_n == s0, "R10 no sync", sync_n, s0);
        end

        // R3 chip-select delay: 3 units at divider 1 -> 6 cycles
        send(16'h2001);
        send(16'h13FB);
        chk(cs_n == 8'hFB, "R3 cs_n with delay", cs_n, 8'hFB);
        count_busy(n);
        chk(n == 6, "R3 delay cycles", n, 6);

        // R8 sleep: 4 units at divider 2 -> 12 cycles
        send(16'h2002);
        send(16'h3103);
        count_busy(n);
        chk(n == 12, "R8 sleep cycles", n, 12);

        // R4 R5 R6 full duplex three bytes
        push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
        send(16'h0302);
        wait_idle();
        chk(sent_n == 3, "R4 byte count", sent_n, 3);
        chk(sent_log[0] == 8'h11 && sent_log[2] == 8'h33, "R5 tx order",
            {sent_log[0], sent_log[2]}, 16'h1133);
        chk(rx_n == 3 && rx_log[1] == (8'h22 ^ 8'hA5), "R6 rx data",
            {rx_n[7:0], rx_log[1]}, {8'd3, 8'h22 ^ 8'hA5});

        // R5 R6 read-only: zeros sent, no pop
        send(16'h0201);
        wait_idle();
        chk(sent_n == 5 && sent_log[3] == 8'h00 && sent_log[4] == 8'h00,
            "R5 zero fill", {sent_n[7:0], sent_log[3]}, 16'h0500);
        chk(tx_rd == 3, "R5 no tx pop", tx_rd, 3);
        chk(rx_n == 5 && rx_log[4] == 8'hA5, "R6 read-only rx", rx_log[4], 8'hA5);

        // R6 write-only: no receive output
        push_tx(8'h44); push_tx(8'h55);
        send(16'h0101);
        wait_idle();
        chk(sent_n == 7 && sent_log[6] == 8'h55, "R5 write-only", sent_log[6], 8'h55);
        chk(rx_n == 5, "R6 no rx when not reading", rx_n, 5);

        // R4 single-byte boundary
        send(16'h0000);
        wait_idle();
        chk(sent_n == 8, "R4 one byte", sent_n, 8);

        // R7 stall on empty transmit queue
        send(16'h0100);
        repeat (20) @(negedge clk);
        chk(sent_n == 8 && !cmd_ready, "R7 tx stall", sent_n, 8);
        push_tx(8'h66);
        wait_idle();
        chk(sent_n == 9 && sent_log[8] == 8'h66, "R7 tx resume", sent_log[8], 8'h66);

        // R7 R9 receive stall holds data and sync
        rx_ready = 1'b0;
        s0 = sync_n;
        fork
            begin
                send(16'h0200);
                send(16'h3042);
            end
            begin
                repeat (25) @(negedge clk);
                held = rx_data;
                chk(rx_valid, "R7 rx offered", rx_valid, 1);
                repeat (5) @(negedge clk);
                chk(rx_valid && rx_data == held, "R7 rx held", rx_data, held);
                chk(sync_n == s0, "R9 sync waits for rx", sync_n, s0);
                rx_ready = 1'b1;
            end
        join
        repeat (2) @(negedge clk);
        chk(rx_n == 6 && rx_log[5] == 8'hA5, "R7 rx released", rx_log[5], 8'hA5);
        chk(sync_n == s0 + 1, "R9 one pulse", sync_n, s0 + 1);
        chk(sync_last == 8'h42 && sync_id == 8'h42, "R9 sync id", sync_id, 8'h42);
        chk(!sync_pulse, "R9 pulse one cycle", sync_pulse, 0);

        // R11 busy during transfer
        send(16'h0203);
        chk(!cmd_ready, "R11 busy in transfer", cmd_ready, 0);
        wait_idle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule